// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns one virtual address into a physical page base by walking a radix page table held in memory. A walk request names the address, one of three paged translation schemes, whether the access is made in supervisor mode, and whether it is a load, a store or an instruction fetch. The caller also supplies the physical base of the root table, which the block samples when it accepts the request. The scheme fixes the depth of the table, the width of each level's index and the size of each entry.

The walker first rejects addresses whose upper bits are not a sign extension of the translated range. It then reads one entry per level through a memory port that allows one access at a time. An entry with no access rights points to the next table. Any other valid entry is a leaf, which must grant the requested access. A leaf found above the last level maps a superpage, and the untranslated low page-number bits pass straight through into the page base. Once a leaf passes its checks, the block writes the accessed flag back into it, together with the dirty flag on a store. Only after that write completes does it return the page base or a fault.

Top module: `pt_walker`

## Requirements
- R1: The scheme field selects the geometry. Code 1 gives 2 levels with 10 index bits and 4-byte entries, code 2 gives 3 levels with 9 index bits and 8-byte entries, and code 3 gives 4 levels with 9 index bits and 8-byte entries. Code 0 faults without any memory access.
- R2: The translated width is 12 + levels × index bits. If address bits 63 down to that width − 1 are neither all zeros nor all ones, the walk faults without any memory access. Addresses with all ones in those bits are walked normally.
- R3: The top level uses the root base and an index shift of (levels − 1) × index bits. At each level the index is the address shifted right by 12 + shift and masked to the index width. The entry address is the base plus index × entry size. The shift drops by the index width at each further level.
- R4: An entry address at or above MEM_BYTES ends the walk with a fault, and that entry is never read.
- R5: The entry fields are: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 5 accessed, bit 6 dirty, and the page number from bit 10 upward. A valid entry with read, write and execute all clear is a table entry, and the next base is its page number shifted left by 12.
- R6: An entry with bit 0 clear faults. A table entry read at the last level also faults.
- R7: A leaf must grant the access. A load needs read, a store needs write and a fetch needs execute. Access code 3 is never granted. A non-supervisor access also needs the user bit. A leaf that fails this check faults with no write.
- R8: A granted leaf is written back exactly once, at its own entry address, as a 32-bit write. The written value is the entry's low 32 bits with the accessed bit set, and with the dirty bit also set when the access is a store. The write completes before the result is given.
- R9: The page base is (page number OR (virtual page number AND (2^shift − 1))) shifted left by 12, where shift is the index shift of the level where the leaf was found.
- R10: A page base at or above MEM_BYTES gives a fault, and the write-back still takes place.
- R11: A memory request is held with its address and type unchanged until it is accepted. Only one access is outstanding at a time. Reads of 4-byte entries are narrow (mem_req_wide low) and use only the low 32 bits of read data. Reads of 8-byte entries are wide.
- R12: After reset, req_ready is high and both mem_req_valid and rsp_valid are low. req_ready stays low for the whole walk. rsp_valid is a one-cycle pulse, and rsp_base is zero on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | XLEN | Virtual address to translate |
| req_scheme | input | 2 | Translation scheme code (R1) |
| req_supervisor | input | 1 | Access made in supervisor mode |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| root_base | input | XLEN | Physical base of the top-level table |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_wide | output | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| mem_req_addr | output | XLEN | Byte address of the access |
| mem_req_wdata | output | 32 | Write data (low half of the entry) |
| mem_rsp_valid | input | 1 | Read data ready or write complete |
| mem_rsp_rdata | input | XLEN | Read data |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_fault | output | 1 | Walk failed |
| rsp_base | output | XLEN | Physical page base on success |

## Verification
The assertions check the port protocol on every cycle. They cover: a pending memory request held stable until accepted; no request while idle; single-cycle result pulses; every memory address below the memory limit; every write-back aimed at the entry last read; and no successful result without an earlier write-back in the same walk. The bench's scenarios cover the rest, because those outcomes depend on the table contents. These are the index arithmetic of each scheme, the choice between table and leaf, superpage base synthesis, the permission rules, the written value with its accessed and dirty flags, and the fault ordering when the final base lies out of range.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PG_SHIFT = 12;
  localparam int PPN_LSB  = 10;
  // entry flag positions
  localparam int F_V = 0;
  localparam int F_R = 1;
  localparam int F_W = 2;
  localparam int F_X = 3;
  localparam int F_U = 4;
  localparam int F_A = 5;
  localparam int F_D = 6;

  typedef enum logic [1:0] {
    SCH_NONE = 2'd0,
    SCH_2L   = 2'd1,
    SCH_3L   = 2'd2,
    SCH_4L   = 2'd3
  } scheme_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef struct packed {
    logic       ok;
    logic [2:0] levels;
    logic [3:0] idx_bits;
    logic       wide;
    logic [6:0] va_bits;
  } geom_t;
endpackage

// File: rtl/pt_walker_geom.sv
module pt_walker_geom
  import pt_walker_pkg::*;
(
  input  scheme_e scheme,
  output geom_t   geom
);
  logic [2:0] lv;
  logic [3:0] ib;
  logic       wd;
  logic       ok;

  always_comb begin
    ok = 1'b1;
    lv = 3'd0;
    ib = 4'd0;
    wd = 1'b0;
    case (scheme)
      SCH_2L: begin lv = 3'd2; ib = 4'd10; wd = 1'b0; end
      SCH_3L: begin lv = 3'd3; ib = 4'd9;  wd = 1'b1; end
      SCH_4L: begin lv = 3'd4; ib = 4'd9;  wd = 1'b1; end
      default: ok = 1'b0;
    endcase
    geom.ok       = ok;
    geom.levels   = lv;
    geom.idx_bits = ib;
    geom.wide     = wd;
    geom.va_bits  = 7'(PG_SHIFT) + 7'(lv) * 7'(ib);
  end
endmodule

// File: rtl/pt_walker_canon.sv
module pt_walker_canon #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] vaddr,
  input  logic [6:0]      va_bits,
  output logic            ok
);
  logic [XLEN-1:0] upper_mask;
  logic [XLEN-1:0] upper;

  assign upper_mask = ~((XLEN'(1) << (va_bits - 7'd1)) - XLEN'(1));
  assign upper      = vaddr & upper_mask;
  assign ok         = (upper == '0) || (upper == upper_mask);
endmodule

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
(
  input  logic [7:0] flags,
  input  logic       supervisor,
  input  access_e    access,
  output logic       granted
);
  logic need;

  always_comb begin
    case (access)
      ACC_LOAD:  need = flags[F_R];
      ACC_STORE: need = flags[F_W];
      ACC_FETCH: need = flags[F_X];
      default:   need = 1'b0;
    endcase
    granted = need && (supervisor || flags[F_U]);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter logic [63:0] MEM_BYTES = 64'h0000_0001_0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic [1:0]      req_scheme,
  input  logic            req_supervisor,
  input  logic [1:0]      req_access,
  input  logic [XLEN-1:0] root_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic            mem_req_wide,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [XLEN-1:0] rsp_base
);
  localparam int              SH_W    = 6;
  localparam logic [XLEN-1:0] MEM_LIM = XLEN'(MEM_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_RD, S_RWAIT, S_DEC, S_WR, S_WWAIT
  } state_e;

  state_e          st;
  logic [XLEN-1:0] va;
  scheme_e         sch;
  logic            sup;
  access_e         acc;
  logic [XLEN-1:0] base;
  logic [SH_W-1:0] shift;
  logic [2:0]      lvl_left;
  logic [XLEN-1:0] pte;
  logic [XLEN-1:0] ent_addr;
  logic [XLEN-1:0] pg_base;

  geom_t           geom;
  logic            canon_ok;
  logic            granted;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] ent_addr_n;
  logic [XLEN-1:0] ppn;
  logic [XLEN-1:0] span_mask;
  logic [XLEN-1:0] leaf_base;
  logic            is_table;

  pt_walker_geom u_geom (
    .scheme (sch),
    .geom   (geom)
  );

  pt_walker_canon #(.XLEN(XLEN)) u_canon (
    .vaddr   (va),
    .va_bits (geom.va_bits),
    .ok      (canon_ok)
  );

  pt_walker_perm u_perm (
    .flags      (pte[7:0]),
    .supervisor (sup),
    .access     (acc),
    .granted    (granted)
  );

  assign idx        = (va >> (7'(PG_SHIFT) + 7'(shift))) &
                      ((XLEN'(1) << geom.idx_bits) - XLEN'(1));
  assign ent_addr_n = base + (idx << (geom.wide ? 3 : 2));
  assign ppn        = pte >> PPN_LSB;
  assign span_mask  = (XLEN'(1) << shift) - XLEN'(1);
  assign leaf_base  = (ppn | ((va >> PG_SHIFT) & span_mask)) << PG_SHIFT;
  assign is_table   = pte[F_V] && !pte[F_R] && !pte[F_W] && !pte[F_X];
  assign req_ready  = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      va            <= '0;
      sch           <= SCH_NONE;
      sup           <= 1'b0;
      acc           <= ACC_LOAD;
      base          <= '0;
      shift         <= '0;
      lvl_left      <= '0;
      pte           <= '0;
      ent_addr      <= '0;
      pg_base       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_wide  <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_base      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            va   <= req_vaddr;
            sch  <= scheme_e'(req_scheme);
            sup  <= req_supervisor;
            acc  <= access_e'(req_access);
            base <= root_base;
            st   <= S_START;
          end
        end
        S_START: begin
          if (!geom.ok || !canon_ok) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_base  <= '0;
            st        <= S_IDLE;
          end else begin
            shift    <= SH_W'(geom.levels - 3'd1) * SH_W'(geom.idx_bits);
            lvl_left <= geom.levels;
            st       <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (ent_addr_n >= MEM_LIM) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_base  <= '0;
            st        <= S_IDLE;
          end else begin
            ent_addr      <= ent_addr_n;
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b0;
            mem_req_wide  <= geom.wide;
            mem_req_addr  <= ent_addr_n;
            st            <= S_RD;
          end
        end
        S_RD: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st            <= S_RWAIT;
          end
        end
        S_RWAIT: begin
          if (mem_rsp_valid) begin
            pte <= geom.wide ? mem_rsp_rdata : XLEN'(mem_rsp_rdata[31:0]);
            st  <= S_DEC;
          end
        end
        S_DEC: begin
          if (!pte[F_V] || (is_table && lvl_left == 3'd1) ||
              (!is_table && !granted)) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_base  <= '0;
            st        <= S_IDLE;
          end else if (is_table) begin
            base     <= ppn << PG_SHIFT;
            shift    <= shift - SH_W'(geom.idx_bits);
            lvl_left <= lvl_left - 3'd1;
            st       <= S_ADDR;
          end else begin
            pg_base       <= leaf_base;
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b1;
            mem_req_wide  <= 1'b0;
            mem_req_addr  <= ent_addr;
            mem_req_wdata <= pte[31:0] | (32'd1 << F_A) |
                             ((acc == ACC_STORE) ? (32'd1 << F_D) : 32'd0);
            st            <= S_WR;
          end
        end
        S_WR: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st            <= S_WWAIT;
          end
        end
        S_WWAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid  <= 1'b1;
            mem_req_we <= 1'b0;
            if (pg_base >= MEM_LIM) begin
              rsp_fault <= 1'b1;
              rsp_base  <= '0;
            end else begin
              rsp_fault <= 1'b0;
              rsp_base  <= pg_base;
            end
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] MEM_BYTES = 64'h0000_0001_0000_0000
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [XLEN-1:0] rsp_base
);
  localparam logic [XLEN-1:0] LIM = XLEN'(MEM_BYTES);

  logic [XLEN-1:0] last_rd;
  logic            wrote;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_rd <= '0;
      wrote   <= 1'b0;
    end else begin
      if (req_valid && req_ready) wrote <= 1'b0;
      if (mem_req_valid && mem_req_ready && !mem_req_we) last_rd <= mem_req_addr;
      if (mem_req_valid && mem_req_ready && mem_req_we) wrote <= 1'b1;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  assert_busy_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_entry_bound_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr < LIM);

  assert_wb_target_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> mem_req_addr == last_rd);

  assert_wb_before_ok_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> wrote);

  assert_base_bound_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> (rsp_base < LIM) && (rsp_base[11:0] == 12'd0));
endmodule

bind pt_walker pt_walker_chk #(.XLEN(XLEN), .MEM_BYTES(MEM_BYTES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_base      (rsp_base)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam logic [63:0] MEMB = 64'h0000_0000_0100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_scheme = '0;
  logic        req_supervisor = 1'b0;
  logic [1:0]  req_access = '0;
  logic [63:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic        mem_req_wide;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [63:0] rsp_base;

  always #4 clk = ~clk;

  pt_walker #(.XLEN(64), .MEM_BYTES(MEMB)) uut (.*);

  int tests = 0;
  int fails = 0;
  int stall = 0;
  int stall_cnt = 0;
  bit hs = 1'b0;

  typedef struct {
    bit          we;
    bit          wide;
    logic [63:0] addr;
    logic [31:0] data;
  } acc_t;
  acc_t exp_q[$];
  bit          exp_fault;
  logic [63:0] exp_base;

  bit [31:0] m32 [longint unsigned];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic bit [31:0] getw(input logic [63:0] a);
    longint unsigned k = a >> 2;
    if (m32.exists(k)) return m32[k];
    return 32'h0;
  endfunction

  task automatic put32(input logic [63:0] a, input logic [31:0] v);
    m32[a >> 2] = v;
  endtask

  task automatic put_pte(input logic [63:0] a, input logic [63:0] v, input int esz);
    put32(a, v[31:0]);
    if (esz == 8) put32(a + 4, v[63:32]);
    else put32(a + 4, 32'hFFFF_FFFF);  // junk beside a narrow entry
  endtask

  function automatic void geo(input int sch, output int lv, output int bits, output int esz);
    lv = 0; bits = 0; esz = 0;
    case (sch)
      1: begin lv = 2; bits = 10; esz = 4; end
      2: begin lv = 3; bits = 9;  esz = 8; end
      3: begin lv = 4; bits = 9;  esz = 8; end
      default: ;
    endcase
  endfunction

  function automatic logic [63:0] vidx(input logic [63:0] va, input int sch, input int k);
    int lv, bits, esz;
    geo(sch, lv, bits, esz);
    return (va >> (12 + (lv - 1 - k) * bits)) & ((64'd1 << bits) - 1);
  endfunction

  function automatic logic [63:0] tab(input logic [63:0] nxt);
    return ((nxt >> 12) << 10) | 64'h1;
  endfunction

  // chain of tables at root, root+4K, ...; leaf placed at depth d
  task automatic build(input int sch, input logic [63:0] root, input logic [63:0] va,
                       input int d, input logic [63:0] leaf);
    int lv, bits, esz;
    geo(sch, lv, bits, esz);
    for (int k = 0; k < d; k++)
      put_pte(root + k * 64'h1000 + vidx(va, sch, k) * esz, tab(root + (k + 1) * 64'h1000), esz);
    put_pte(root + d * 64'h1000 + vidx(va, sch, d) * esz, leaf, esz);
  endtask

  function automatic bit perm(input logic [63:0] p, input bit sup, input int acc);
    bit need;
    case (acc)
      0: need = p[1];
      1: need = p[2];
      2: need = p[3];
      default: need = 1'b0;
    endcase
    return need && (sup || p[4]);
  endfunction

  function automatic void ref_walk(input logic [63:0] va, input int sch, input bit sup,
                                   input int acc, input logic [63:0] root);
    int lv, bits, esz, vab, sh;
    logic [63:0] base, ea, p, hi, pb, allone;
    acc_t e;
    exp_q.delete();
    exp_fault = 1'b1;
    exp_base = '0;
    geo(sch, lv, bits, esz);
    if (lv == 0) return;
    vab = 12 + lv * bits;
    hi = va >> (vab - 1);
    allone = 64'hFFFF_FFFF_FFFF_FFFF >> (vab - 1);
    if (hi != 0 && hi != allone) return;
    base = root;
    sh = (lv - 1) * bits;
    for (int i = 0; i < lv; i++) begin
      ea = base + ((va >> (12 + sh)) & ((64'd1 << bits) - 1)) * esz;
      if (ea >= MEMB) return;
      e.we = 1'b0; e.wide = (esz == 8); e.addr = ea; e.data = '0;
      exp_q.push_back(e);
      p = (esz == 8) ? {getw(ea + 4), getw(ea)} : {32'h0, getw(ea)};
      if (!p[0]) return;
      if (p[3:1] == 3'b000) begin
        base = (p >> 10) << 12;
        sh -= bits;
        continue;
      end
      if (!perm(p, sup, acc)) return;
      e.we = 1'b1; e.wide = 1'b0; e.addr = ea;
      e.data = p[31:0] | 32'h20 | ((acc == 1) ? 32'h40 : 32'h0);
      exp_q.push_back(e);
      pb = ((p >> 10) | ((va >> 12) & ((64'd1 << sh) - 1))) << 12;
      if (pb < MEMB) begin
        exp_fault = 1'b0;
        exp_base = pb;
      end
      return;
    end
  endfunction

  // behavioural memory: inputs driven on the falling edge
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst) begin
      mem_req_ready = 1'b0;
      hs = 1'b0;
      stall_cnt = 0;
    end else if (hs) begin
      acc_t e;
      hs = 1'b0;
      mem_req_ready = 1'b0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected memory access at", mem_req_addr, 64'h0);
      end else begin
        e = exp_q.pop_front();
        chk(e.we == mem_req_we && e.addr == mem_req_addr, e.we ? "R8" : "R3",
            "access address", mem_req_addr, e.addr);
        chk(e.wide == mem_req_wide, "R11", "access width", 64'(mem_req_wide), 64'(e.wide));
        if (e.we) chk(mem_req_wdata == e.data, "R8", "write-back value",
                      64'(mem_req_wdata), 64'(e.data));
      end
      if (mem_req_we) put32(mem_req_addr, mem_req_wdata);
      else mem_rsp_rdata = {getw(mem_req_addr + 4), getw(mem_req_addr)};
      mem_rsp_valid = 1'b1;
    end else if (mem_req_valid && !mem_req_ready) begin
      if (stall_cnt < stall) stall_cnt++;
      else begin
        stall_cnt = 0;
        mem_req_ready = 1'b1;
        hs = 1'b1;
      end
    end
  end

  task automatic walk(input string req, input logic [63:0] va, input int sch,
                      input bit sup, input int acc, input logic [63:0] root);
    int waited;
    ref_walk(va, sch, sup, acc, root);
    @(negedge clk);
    chk(req_ready, "R12", "ready before request", 64'(req_ready), 64'h1);
    req_valid = 1'b1;
    req_vaddr = va;
    req_scheme = 2'(sch);
    req_supervisor = sup;
    req_access = 2'(acc);
    root_base = root;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready || rsp_valid, "R12", "ready during walk", 64'(req_ready), 64'h0);
    waited = 0;
    while (!rsp_valid && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    chk(rsp_valid, req, "result arrived", 64'(rsp_valid), 64'h1);
    chk(rsp_fault == exp_fault, req, "fault flag", 64'(rsp_fault), 64'(exp_fault));
    chk(rsp_base == exp_base, req, "page base", rsp_base, exp_base);
    chk(exp_q.size() == 0, req, "accesses left over", 64'(exp_q.size()), 64'h0);
    @(negedge clk);
    chk(!rsp_valid, "R12", "result pulse width", 64'(rsp_valid), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R12", "reset req_ready", 64'(req_ready), 64'h1);
    chk(mem_req_valid == 1'b0, "R12", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);
    chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", 64'(rsp_valid), 64'h0);

    // three-level 4K leaf, supervisor load, then store sets dirty
    build(2, 64'h10_0000, 64'h0000_0012_3456_7ABC, 2, (64'h345 << 10) | 64'h07);
    walk("R5", 64'h0000_0012_3456_7ABC, 2, 1'b1, 0, 64'h10_0000);
    chk(exp_base == 64'h345000, "R3", "three-level base", exp_base, 64'h345000);
    walk("R8", 64'h0000_0012_3456_7ABC, 2, 1'b1, 1, 64'h10_0000);

    // two-level narrow entries with junk beside them, user fetch
    build(1, 64'h20_0000, 64'h1234_5ABC, 1, (64'h123 << 10) | 64'h19);
    walk("R11", 64'h1234_5ABC, 1, 1'b0, 2, 64'h20_0000);
    chk(exp_base == 64'h123000, "R1", "two-level base", exp_base, 64'h123000);

    // four-level walk
    build(3, 64'h30_0000, 64'h0000_7ABC_D123_4000, 3, (64'hABC << 10) | 64'h03);
    walk("R1", 64'h0000_7ABC_D123_4000, 3, 1'b1, 0, 64'h30_0000);

    // superpages: 2 MiB and 1 GiB
    build(2, 64'h40_0000, 64'h0000_0000_0030_5000, 1, (64'h400 << 10) | 64'h03);
    walk("R9", 64'h0000_0000_0030_5000, 2, 1'b1, 0, 64'h40_0000);
    chk(exp_base == 64'h505000, "R9", "2 MiB base", exp_base, 64'h505000);
    build(2, 64'h50_0000, 64'h0000_0000_4000_5000, 0, 64'h03);
    walk("R9", 64'h0000_0000_4000_5000, 2, 1'b1, 0, 64'h50_0000);

    // sign extension: upper ones walk, mixed upper faults
    build(2, 64'h60_0000, 64'hFFFF_FFC0_0000_1000, 2, (64'h77 << 10) | 64'h03);
    walk("R2", 64'hFFFF_FFC0_0000_1000, 2, 1'b1, 0, 64'h60_0000);
    walk("R2", 64'h0000_0040_0000_0000, 2, 1'b1, 0, 64'h60_0000);

    // unsupported scheme
    walk("R1", 64'h0000_0012_3456_7ABC, 0, 1'b1, 0, 64'h10_0000);

    // permission failures
    build(2, 64'h70_0000, 64'h0000_0000_0000_3000, 2, (64'h55 << 10) | 64'h03);
    walk("R7", 64'h0000_0000_0000_3000, 2, 1'b1, 1, 64'h70_0000);
    walk("R7", 64'h0000_0000_0000_3000, 2, 1'b0, 0, 64'h70_0000);
    walk("R7", 64'h0000_0000_0000_3000, 2, 1'b1, 2, 64'h70_0000);
    walk("R7", 64'h0000_0000_0000_3000, 2, 1'b1, 3, 64'h70_0000);

    // invalid entry and table at last level
    build(2, 64'h80_0000, 64'h0000_0000_0000_4000, 1, 64'h0);
    walk("R6", 64'h0000_0000_0000_4000, 2, 1'b1, 0, 64'h80_0000);
    build(1, 64'h90_0000, 64'h0000_5000, 1, tab(64'h90_0000));
    walk("R6", 64'h0000_5000, 1, 1'b1, 0, 64'h90_0000);

    // entry address out of memory: root and second level
    walk("R4", 64'h0000_0012_3456_7ABC, 2, 1'b1, 0, 64'h0200_0000);
    build(2, 64'hA0_0000, 64'h0000_0000_0000_6000, 0, tab(64'h0300_0000));
    walk("R4", 64'h0000_0000_0000_6000, 2, 1'b1, 0, 64'hA0_0000);

    // page base out of memory: write-back still happens
    build(2, 64'hB0_0000, 64'h0000_0000_0000_7000, 2, (64'h2000 << 10) | 64'h03);
    walk("R10", 64'h0000_0000_0000_7000, 2, 1'b1, 0, 64'hB0_0000);

    // back-pressure on the memory port
    stall = 3;
    walk("R11", 64'h0000_7ABC_D123_4000, 3, 1'b1, 1, 64'h30_0000);
    walk("R11", 64'h1234_5ABC, 1, 1'b0, 2, 64'h20_0000);
    stall = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule